// File: doc/BRIEF.md
# GPIO Port Controller

A sixteen-pin general-purpose I/O port behind a small 32-bit register bus. Software sets, per pin, a direction (input or general output), a drive style (push-pull or open-drain) and a bias (pull-up, pull-down or none), and owns an output data word. That word can also be changed bit-by-bit through two write-only registers, so single pins change without a read-modify-write.

Each pin's level is resolved every cycle from its configuration, its output bit and an external drive model. The model gives each pin a "driving" flag and a level. When the port takes a pin as an output, it may cut off the external driver. A cut-off driver stays cut off until the environment presents a fresh drive while the pin is an input. The resolved levels come out both as a readable input-data register and as a per-pin level vector, which goes to an interrupt or event controller. Mode codes other than general output (alternate and analog) behave as plain input.

The register bus is a plain control interface: one access per cycle, write strobe, combinational read data, no handshake.

Top module: `pinbank_ctrl`

## Requirements
- R1: After reset, the mode register reads `MODE_RST`, the pull register reads `PULL_RST`, output type and output data read 0, and every disconnect flag is 0.
- R2: Read and write offsets are 0x00 mode (bits [2p+1:2p] for pin p), 0x04 output type (bit p), 0x0C pull (bits [2p+1:2p]) and 0x14 output data (bit p). Bits above 15 of output type and output data read 0. Reads of 0x18, 0x28 and unmapped offsets return 0. A write to 0x10 changes no register.
- R3: A write to 0x18 sets output bit p for each 1 in bit p (0..15) and clears output bit p for each 1 in bit p+16. When both bits are 1, the set wins. Zero bits leave the output unchanged.
- R4: A write to 0x28 clears output bit p for each 1 in bit p (0..15). Bits 31:16 and zero bits leave the output unchanged.
- R5: For an input pin (mode 00, 10 or 11), a connected external driver gives its level. Without one, pull code 01 gives 1, 10 gives 0, and 00 or 11 gives the pin's `IDLE_LVL` bit.
- R6: For a push-pull output pin (mode 01, type 0), the level equals its output bit. Output bits written while the pin is an input are kept and appear once the pin becomes an output.
- R7: For an open-drain output pin (mode 01, type 1), the level is 0 when a connected driver drives low, and otherwise equals its output bit.
- R8: One cycle after an output pin sees a driver that is push-pull-driving, or that drives high on an open-drain pin, the pin's disconnect flag is 1. A disconnected driver has no effect on the pin level.
- R9: The disconnect flag clears one cycle after an input pin sees a new drive: the driving flag rises, or the level changes while the pin is driven.
- R10: The input-data register (0x10, bit p) and the `pin_level_o` vector show the resolved level in the same cycle as the state that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Write strobe for the register bus |
| reg_addr | input | 6 | Byte offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| ext_drive_en | input | 16 | Per-pin external driver present |
| ext_drive_lvl | input | 16 | Per-pin external driver level |
| pin_level_o | output | 16 | Resolved level per pin, toward an event controller |
| pin_cut_o | output | 16 | Per-pin flag: external driver disconnected |

## Verification
A register write takes effect at the clock edge that samples the strobe. The bench drives every access on a falling edge and reads back after the next falling edge. Resolved levels and read data are combinational, so the bench samples them one time step after changing the address or the external drive, with no edge in between. Disconnect flags are registered and change one edge after the condition appears, so each flag is checked on the falling edge that follows the stimulus. Input resolution is swept over every pull code against several drive-enable and level patterns on all sixteen pins, with the expected word computed bit by bit.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned ADDR_W  = 6;
  localparam int unsigned CLR_LSB = 16;

  typedef enum logic [ADDR_W-1:0] {
    OFS_MODE   = 6'h00,
    OFS_OTYPE  = 6'h04,
    OFS_PULL   = 6'h0C,
    OFS_LEVEL  = 6'h10,
    OFS_OUT    = 6'h14,
    OFS_SETCLR = 6'h18,
    OFS_CLR    = 6'h28
  } reg_ofs_e;

  localparam logic [1:0] MODE_GP_OUT = 2'b01;
  localparam logic [1:0] BIAS_UP     = 2'b01;
  localparam logic [1:0] BIAS_DOWN   = 2'b10;
endpackage

// File: rtl/pinbank_regs.sv
module pinbank_regs
  import pinbank_pkg::*;
#(
  parameter int unsigned PIN_COUNT = 16,
  parameter logic [31:0] MODE_RST  = 32'h0,
  parameter logic [31:0] PULL_RST  = 32'h0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      wdata,
  input  logic [PIN_COUNT-1:0]   level_i,
  output logic [DATA_W-1:0]      rdata,
  output logic [2*PIN_COUNT-1:0] mode_o,
  output logic [PIN_COUNT-1:0]   otype_o,
  output logic [2*PIN_COUNT-1:0] pull_o,
  output logic [PIN_COUNT-1:0]   out_o
);
  localparam int unsigned FLD_W = 2 * PIN_COUNT;

  logic [FLD_W-1:0]     mode_q, pull_q;
  logic [PIN_COUNT-1:0] otype_q, out_q;
  logic [PIN_COUNT-1:0] set_bits, clr_bits;

  assign set_bits = wdata[PIN_COUNT-1:0];
  assign clr_bits = wdata[CLR_LSB +: PIN_COUNT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= MODE_RST[FLD_W-1:0];
      pull_q  <= PULL_RST[FLD_W-1:0];
      otype_q <= '0;
      out_q   <= '0;
    end else if (we) begin
      case (addr)
        OFS_MODE:   mode_q  <= wdata[FLD_W-1:0];
        OFS_OTYPE:  otype_q <= wdata[PIN_COUNT-1:0];
        OFS_PULL:   pull_q  <= wdata[FLD_W-1:0];
        OFS_OUT:    out_q   <= wdata[PIN_COUNT-1:0];
        OFS_SETCLR: out_q   <= (out_q & ~clr_bits) | set_bits;
        OFS_CLR:    out_q   <= out_q & ~set_bits;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_MODE:  rdata = DATA_W'(mode_q);
      OFS_OTYPE: rdata = DATA_W'(otype_q);
      OFS_PULL:  rdata = DATA_W'(pull_q);
      OFS_LEVEL: rdata = DATA_W'(level_i);
      OFS_OUT:   rdata = DATA_W'(out_q);
      default:   rdata = '0;
    endcase
  end

  assign mode_o  = mode_q;
  assign otype_o = otype_q;
  assign pull_o  = pull_q;
  assign out_o   = out_q;

  // R3: every bit asked to be set is high after the write, clear bits notwithstanding
  a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == OFS_SETCLR) |=> ((out_q & $past(set_bits)) == $past(set_bits)));

  // R4: every bit named in the reset-only write is low afterwards
  a_r4_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == OFS_CLR) |=> ((out_q & $past(set_bits)) == '0));

  // R2: the input-data offset is not writable
  a_r2_level_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == OFS_LEVEL) |=> ($stable(mode_q) && $stable(pull_q) &&
                                   $stable(otype_q) && $stable(out_q)));
endmodule

// File: rtl/pinbank_pin.sv
module pinbank_pin
  import pinbank_pkg::*;
#(
  parameter logic IDLE = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       drain,
  input  logic [1:0] bias,
  input  logic       out_bit,
  input  logic       drv_en,
  input  logic       drv_lvl,
  output logic       level_o,
  output logic       cut_o
);
  logic is_out, live, fresh, grab;
  logic prev_en, prev_lvl, cut_q;

  assign is_out = (mode == MODE_GP_OUT);
  assign live   = drv_en & ~cut_q;
  assign fresh  = drv_en & (~prev_en | (prev_lvl ^ drv_lvl));
  assign grab   = is_out & drv_en & (~drain | drv_lvl);

  always_comb begin
    if (is_out) begin
      level_o = drain ? (out_bit & ~(live & ~drv_lvl)) : out_bit;
    end else if (live) begin
      level_o = drv_lvl;
    end else begin
      case (bias)
        BIAS_UP:   level_o = 1'b1;
        BIAS_DOWN: level_o = 1'b0;
        default:   level_o = IDLE;
      endcase
    end
  end

  // previous drive sample; compared against the present one to spot a new drive
  always_ff @(posedge clk) begin
    prev_en  <= drv_en;
    prev_lvl <= drv_lvl;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                cut_q <= 1'b0;
    else if (grab)             cut_q <= 1'b1;
    else if (!is_out && fresh) cut_q <= 1'b0;
  end

  assign cut_o = cut_q;

  // R8: a driver fighting a push-pull output is cut one cycle later
  a_r8_pp_cut: assert property (@(posedge clk) disable iff (!rst_n)
    (is_out && !drain && drv_en) |=> cut_q);

  // R8: a disconnect only ever follows a cycle in output mode
  a_r8_cut_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cut_q) |-> $past(is_out));

  // R9: a level change on a driven input pin reconnects the driver
  a_r9_reconnect: assert property (@(posedge clk) disable iff (!rst_n)
    (cut_q && !is_out && drv_en && !$stable(drv_lvl)) |=> !cut_q);
endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
  import pinbank_pkg::*;
#(
  parameter int unsigned PIN_COUNT = 16,
  parameter logic [31:0] MODE_RST  = 32'h0,
  parameter logic [31:0] PULL_RST  = 32'h0,
  parameter logic [15:0] IDLE_LVL  = 16'h0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  input  logic [PIN_COUNT-1:0] ext_drive_en,
  input  logic [PIN_COUNT-1:0] ext_drive_lvl,
  output logic [PIN_COUNT-1:0] pin_level_o,
  output logic [PIN_COUNT-1:0] pin_cut_o
);
  localparam int unsigned FLD_W = 2 * PIN_COUNT;

  logic [FLD_W-1:0]     mode_w, pull_w;
  logic [PIN_COUNT-1:0] otype_w, out_w, level_w;

  pinbank_regs #(
    .PIN_COUNT(PIN_COUNT), .MODE_RST(MODE_RST), .PULL_RST(PULL_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .level_i(level_w), .rdata(reg_rdata), .mode_o(mode_w), .otype_o(otype_w),
    .pull_o(pull_w), .out_o(out_w)
  );

  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
    pinbank_pin #(.IDLE(IDLE_LVL[p])) u_pin (
      .clk(clk), .rst_n(rst_n),
      .mode(mode_w[2*p +: 2]), .drain(otype_w[p]), .bias(pull_w[2*p +: 2]),
      .out_bit(out_w[p]), .drv_en(ext_drive_en[p]), .drv_lvl(ext_drive_lvl[p]),
      .level_o(level_w[p]), .cut_o(pin_cut_o[p])
    );
  end

  assign pin_level_o = level_w;

  // R10: the readable input-data word and the level vector never disagree
  a_r10_level_view: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == OFS_LEVEL) |-> (reg_rdata[PIN_COUNT-1:0] == pin_level_o));
endmodule

// File: tb/tb_pinbank_ctrl.sv
module tb_pinbank_ctrl;
  localparam logic [31:0] T_MODE_RST = 32'hABFFFFFF;
  localparam logic [31:0] T_PULL_RST = 32'h64000000;
  localparam logic [15:0] T_IDLE     = 16'h0F00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] ext_drive_en = '0, ext_drive_lvl = '0;
  logic [15:0] pin_level_o, pin_cut_o;

  int checks = 0, errors = 0;

  pinbank_ctrl #(.PIN_COUNT(16), .MODE_RST(T_MODE_RST), .PULL_RST(T_PULL_RST),
                 .IDLE_LVL(T_IDLE)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_drive_en(ext_drive_en),
    .ext_drive_lvl(ext_drive_lvl), .pin_level_o(pin_level_o), .pin_cut_o(pin_cut_o)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic drive(input logic [15:0] en, input logic [15:0] lvl);
    @(negedge clk);
    ext_drive_en = en; ext_drive_lvl = lvl;
    #1;
  endtask

  function automatic logic [15:0] exp_input(input logic [31:0] pw, input logic [15:0] en,
                                            input logic [15:0] lvl);
    logic [15:0] e;
    for (int i = 0; i < 16; i++) begin
      if (en[i])                 e[i] = lvl[i];
      else if (pw[2*i +: 2] == 2'b01) e[i] = 1'b1;
      else if (pw[2*i +: 2] == 2'b10) e[i] = 1'b0;
      else                       e[i] = T_IDLE[i];
    end
    return e;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    logic [15:0] ens [5];
    logic [15:0] lvls[3];
    ens[0] = 16'h0000; ens[1] = 16'hFFFF; ens[2] = 16'h00FF; ens[3] = 16'hA5A5; ens[4] = 16'h3C3C;
    lvls[0] = 16'h0000; lvls[1] = 16'hFFFF; lvls[2] = 16'h5A0F;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state (R5: reset modes 10/11 behave as input)
    rd(6'h00, d); chk("R1 mode reset", d, T_MODE_RST);
    rd(6'h0C, d); chk("R1 pull reset", d, T_PULL_RST);
    rd(6'h04, d); chk("R1 otype reset", d, 32'h0);
    rd(6'h14, d); chk("R1 out reset", d, 32'h0);
    chk("R1 cut reset", {16'h0, pin_cut_o}, 32'h0);
    rd(6'h10, d); chk("R5 reset level", d, {16'h0, exp_input(T_PULL_RST, 16'h0, 16'h0)});

    // R2 register map
    wr(6'h04, 32'hFFFFFFFF);
    rd(6'h04, d); chk("R2 otype width", d, 32'h0000FFFF);
    wr(6'h04, 32'h0);
    wr(6'h10, 32'h12345678);
    rd(6'h00, d); chk("R2 level write ignored", d, T_MODE_RST);
    rd(6'h14, d); chk("R2 level write out", d, 32'h0);
    wr(6'h18, 32'h00000001);
    rd(6'h18, d); chk("R2 setclr reads 0", d, 32'h0);
    rd(6'h28, d); chk("R2 clr reads 0", d, 32'h0);
    rd(6'h08, d); chk("R2 unmapped reads 0", d, 32'h0);

    // R5/R10 sweep: all inputs, every pull code against drive patterns
    wr(6'h00, 32'h0);
    for (int pv = 0; pv < 4; pv++) begin
      logic [31:0] pw;
      pw = {16{pv[1:0]}};
      wr(6'h0C, pw);
      for (int ei = 0; ei < 5; ei++) begin
        for (int li = 0; li < 3; li++) begin
          drive(ens[ei], lvls[li]);
          rd(6'h10, d);
          chk("R5 input resolve", d, {16'h0, exp_input(pw, ens[ei], lvls[li])});
          chk("R10 level vector", {16'h0, pin_level_o}, {16'h0, exp_input(pw, ens[ei], lvls[li])});
        end
      end
    end
    wr(6'h0C, 32'h0);
    drive(16'h0, 16'h0);
    chk("R9 no cut in input", {16'h0, pin_cut_o}, 32'h0);

    // R3 / R4 set, clear, priority
    wr(6'h14, 32'h0);
    wr(6'h18, 32'h00000003);
    rd(6'h14, d); chk("R3 set", d, 32'h3);
    wr(6'h18, 32'h00010000);
    rd(6'h14, d); chk("R3 clear", d, 32'h2);
    wr(6'h18, 32'h00040004);
    rd(6'h14, d); chk("R3 set wins", d, 32'h6);
    wr(6'h18, 32'h0);
    rd(6'h14, d); chk("R3 zero unchanged", d, 32'h6);
    wr(6'h28, 32'h00000004);
    rd(6'h14, d); chk("R4 clear", d, 32'h2);
    wr(6'h28, 32'hFFFF0000);
    rd(6'h14, d); chk("R4 upper ignored", d, 32'h2);

    // R6 push-pull on pin 5 (idle 0, no pull)
    wr(6'h14, 32'h00000020);
    rd(6'h10, d); chk("R6 stored not applied", d & 32'h20, 32'h0);
    wr(6'h00, 32'h00000400);
    rd(6'h10, d); chk("R6 output applied", d & 32'h20, 32'h20);
    // R8 driver on push-pull output
    drive(16'h0020, 16'h0000);
    chk("R6 pp ignores low driver", {16'h0, pin_level_o} & 32'h20, 32'h20);
    @(negedge clk); #1;
    chk("R8 pp cut", {16'h0, pin_cut_o} & 32'h20, 32'h20);
    drive(16'h0020, 16'h0020);
    wr(6'h00, 32'h0);
    rd(6'h10, d); chk("R8 cut driver ignored", d & 32'h20, 32'h0);
    chk("R8 cut held", {16'h0, pin_cut_o} & 32'h20, 32'h20);
    // R9 reconnect on new drive
    drive(16'h0020, 16'h0000);
    @(negedge clk); #1;
    chk("R9 reconnect", {16'h0, pin_cut_o} & 32'h20, 32'h0);
    drive(16'h0020, 16'h0020);
    chk("R9 driver live", {16'h0, pin_level_o} & 32'h20, 32'h20);

    // R7 open-drain on pin 3
    drive(16'h0028, 16'h0020);
    wr(6'h04, 32'h00000008);
    wr(6'h14, 32'h00000008);
    wr(6'h00, 32'h00000040);
    rd(6'h10, d); chk("R7 od low wins", d & 32'h8, 32'h0);
    chk("R7 od low stays", {16'h0, pin_cut_o} & 32'h8, 32'h0);
    drive(16'h0028, 16'h0028);
    chk("R7 od high shows out", {16'h0, pin_level_o} & 32'h8, 32'h8);
    @(negedge clk); #1;
    chk("R8 od high cut", {16'h0, pin_cut_o} & 32'h8, 32'h8);
    drive(16'h0028, 16'h0020);
    chk("R8 od cut low ignored", {16'h0, pin_level_o} & 32'h8, 32'h8);
    wr(6'h18, 32'h00080000);
    rd(6'h10, d); chk("R7 od out low", d & 32'h8, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule